// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block produces and checks the single even-parity bit that guards a 32-bit multiplexed address/data bus and its 4-bit active-low command/byte-enable lines. It watches the framing strobes to find address phases and data phases. It captures the parity of every such phase on the clock where the phase is sampled. The resulting bit goes out on the next clock, together with an output enable, whenever this agent owns parity for that phase.

Which agent owns parity depends on the phase and on the transfer direction. The initiator covers address phases and write data. The target covers read data. The block learns its role (initiator or target) and the direction at the address phase and keeps them for the rest of the transaction. When the other agent owns parity, the block compares the incoming bit, sampled one clock after the phase, against its own captured value. On a mismatch it raises a one-clock error pulse. Reporting the error on the bus, arbitration and command decoding are left to neighbouring logic.

Top module: `bus_parity_unit`

## Requirements
- R1: Parity is even over 36 bits. Whenever `par_oe_o` is high, the number of ones in `par_o`, `ad_i` and `cbe_n_i` (both sampled at the preceding clock edge) is even. This holds with command values in the address phase and with active-low byte enables in data phases.
- R2: An address phase is a clock edge where `frame_n_i` is sampled low and the previous edge sampled both `frame_n_i` and `irdy_n_i` high. The parity of that phase is presented in the clock period following that edge.
- R3: After an address phase, `par_oe_o` is high for one clock when `initiator_i` was 1 at that phase. It stays low when `initiator_i` was 0 (target).
- R4: In a write transaction (`write_i`=1 at the address phase), each data-phase edge with `irdy_n_i` low makes `par_oe_o` high in the following clock when this agent is the initiator. It stays low when this agent is the target.
- R5: In a read transaction (`write_i`=0), each data-phase edge with `trdy_n_i` low makes `par_oe_o` high in the following clock when this agent is the target. It stays low when this agent is the initiator.
- R6: Role and direction are taken only at the address phase. Changes on `initiator_i` or `write_i` during data phases have no effect on `par_oe_o` or on the phase qualification.
- R7: A data phase completes on an edge with `irdy_n_i` and `trdy_n_i` both low. In the clock after completion, `par_o` still carries that phase's parity, with `par_oe_o` high if this agent owned it. A completion with `frame_n_i` high ends the transaction.
- R8: When this agent does not own parity for a phase, `par_i` is sampled on the next edge and compared with the captured value. On a mismatch, `perr_pulse_o` is high for exactly the one clock after that sampling edge.
- R9: Phases whose parity this agent drives are never compared. A wrong `par_i` on those phases leaves `perr_pulse_o` low.
- R10: While `rst` is sampled high, `par_oe_o` and `perr_pulse_o` are low in the following clock and the bus is treated as idle.
- R11: Strobe activity outside a transaction (no address phase since the bus was last idle) is ignored: `par_oe_o` stays low and nothing is compared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ad_i | input | 32 | Multiplexed address/data lines |
| cbe_n_i | input | 4 | Command (address phase) or active-low byte enables (data phase) |
| frame_n_i | input | 1 | Transaction frame, active low |
| irdy_n_i | input | 1 | Initiator ready, active low |
| trdy_n_i | input | 1 | Target ready, active low |
| initiator_i | input | 1 | 1 when this agent starts the transaction, 0 when it is the target |
| write_i | input | 1 | 1 for a write transaction, 0 for a read |
| par_i | input | 1 | Parity bit as seen on the bus |
| par_o | output | 1 | Generated parity bit |
| par_oe_o | output | 1 | Output enable for `par_o` |
| perr_pulse_o | output | 1 | One-clock parity mismatch pulse |

## Verification
The hardest situation to reach from the ports is a mismatch on a phase whose parity the other agent owns. This covers an address phase received as target and a data phase received as a read initiator or a write target. The wrong bit has to arrive exactly one edge after the phase, while an unrelated phase may already be running. The vector table builds full transactions for all four combinations of role and direction. It derives the incoming bit from the previous vector's lines, either right or deliberately wrong. It also flips the role and direction inputs in the middle of a transaction, so that any use of the live inputs instead of the latched ones would change the enable.

// File: rtl/bpu_pkg.sv
package bpu_pkg;
  // One qualified bus phase: whether it fired this edge and whether
  // this agent owns the parity bit for it.
  typedef struct packed {
    logic fire;
    logic drive;
  } phase_evt_t;
endpackage

// File: rtl/bpu_phase_track.sv
module bpu_phase_track
  import bpu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       frame_n_i,
  input  logic       irdy_n_i,
  input  logic       trdy_n_i,
  input  logic       initiator_i,
  input  logic       write_i,
  output phase_evt_t evt_o
);
  logic idle_q;
  logic in_data_q;
  logic role_q;
  logic write_q;
  logic addr_phase;
  logic data_evt;
  logic txn_close;

  assign addr_phase = idle_q & ~frame_n_i;
  assign data_evt   = in_data_q & (write_q ? ~irdy_n_i : ~trdy_n_i);
  // Transaction ends on an idle bus or on the final completed phase.
  assign txn_close  = frame_n_i & (irdy_n_i | ~trdy_n_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_q    <= 1'b1;
      in_data_q <= 1'b0;
      role_q    <= 1'b0;
      write_q   <= 1'b0;
    end else begin
      idle_q <= frame_n_i & irdy_n_i;
      if (addr_phase) begin
        in_data_q <= 1'b1;
        role_q    <= initiator_i;
        write_q   <= write_i;
      end else if (txn_close) begin
        in_data_q <= 1'b0;
      end
    end
  end

  always_comb begin
    evt_o.fire  = addr_phase | data_evt;
    // Initiator owns write data, target owns read data.
    evt_o.drive = addr_phase ? initiator_i : (role_q == write_q);
  end

  // R2: an address phase always opens a data window on the next clock
  assert_addr_opens_data_R2: assert property (@(posedge clk) disable iff (rst)
    addr_phase |=> in_data_q);

  // R11: an address phase and a data phase never qualify on the same edge
  assert_phase_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
    !(addr_phase && data_evt));
endmodule

// File: rtl/bpu_par_gen.sv
module bpu_par_gen
  import bpu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BE_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] ad_i,
  input  logic [BE_W-1:0]   cbe_n_i,
  input  phase_evt_t        evt_i,
  output logic              par_o,
  output logic              oe_o
);
  localparam int LANE_W = DATA_W / BE_W;

  logic [BE_W-1:0] lane_par;
  logic            par_now;
  logic            par_q;
  logic            oe_q;

  // Per byte lane: fold the lane's data bits with its enable bit.
  for (genvar l = 0; l < BE_W; l++) begin : g_lane
    assign lane_par[l] = (^ad_i[l*LANE_W +: LANE_W]) ^ cbe_n_i[l];
  end
  assign par_now = ^lane_par;

  always_ff @(posedge clk) begin
    if (rst) begin
      par_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      oe_q <= evt_i.fire & evt_i.drive;
      if (evt_i.fire) par_q <= par_now;
    end
  end

  assign par_o = par_q;
  assign oe_o  = oe_q;

  // R3/R4/R5: the enable only follows a qualified phase this agent owns
  assert_oe_follows_phase_R3: assert property (@(posedge clk) disable iff (rst)
    oe_q |-> ($past(evt_i.fire) && $past(evt_i.drive)));
endmodule

// File: rtl/bpu_par_check.sv
module bpu_par_check
  import bpu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  phase_evt_t evt_i,
  input  logic       cap_par_i,
  input  logic       par_i,
  output logic       chk_o,
  output logic       perr_o
);
  logic chk_q;
  logic perr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_q  <= 1'b0;
      perr_q <= 1'b0;
    end else begin
      chk_q  <= evt_i.fire & ~evt_i.drive;
      perr_q <= chk_q & (par_i != cap_par_i);
    end
  end

  assign chk_o  = chk_q;
  assign perr_o = perr_q;

  // R8: a pulse needs a compare window on the edge before it
  assert_pulse_needs_check_R8: assert property (@(posedge clk) disable iff (rst)
    perr_q |-> $past(chk_q));
endmodule

// File: rtl/bus_parity_unit.sv
module bus_parity_unit
  import bpu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BE_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] ad_i,
  input  logic [BE_W-1:0]   cbe_n_i,
  input  logic              frame_n_i,
  input  logic              irdy_n_i,
  input  logic              trdy_n_i,
  input  logic              initiator_i,
  input  logic              write_i,
  input  logic              par_i,
  output logic              par_o,
  output logic              par_oe_o,
  output logic              perr_pulse_o
);
  phase_evt_t evt;
  logic       chk_pending;

  bpu_phase_track u_track (
    .clk         (clk),
    .rst         (rst),
    .frame_n_i   (frame_n_i),
    .irdy_n_i    (irdy_n_i),
    .trdy_n_i    (trdy_n_i),
    .initiator_i (initiator_i),
    .write_i     (write_i),
    .evt_o       (evt)
  );

  bpu_par_gen #(.DATA_W(DATA_W), .BE_W(BE_W)) u_gen (
    .clk     (clk),
    .rst     (rst),
    .ad_i    (ad_i),
    .cbe_n_i (cbe_n_i),
    .evt_i   (evt),
    .par_o   (par_o),
    .oe_o    (par_oe_o)
  );

  bpu_par_check u_check (
    .clk       (clk),
    .rst       (rst),
    .evt_i     (evt),
    .cap_par_i (par_o),
    .par_i     (par_i),
    .chk_o     (chk_pending),
    .perr_o    (perr_pulse_o)
  );

  // R1: driven parity makes the 36-bit set even
  assert_even_parity_R1: assert property (@(posedge clk) disable iff (rst)
    par_oe_o |-> ((^{par_o, $past(ad_i), $past(cbe_n_i)}) == 1'b0));

  // R9: never compare a phase this agent is driving
  assert_no_self_check_R9: assert property (@(posedge clk) disable iff (rst)
    !(par_oe_o && chk_pending));

  // R10: reset leaves the outputs quiet
  assert_reset_quiet_R10: assert property (@(posedge clk)
    rst |=> (!par_oe_o && !perr_pulse_o));
endmodule

// File: tb/bus_parity_unit_tb_top.sv
module bus_parity_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        rst;
    logic        frame_n;
    logic        irdy_n;
    logic        trdy_n;
    logic        ini;
    logic        wr;
    logic [31:0] ad;
    logic [3:0]  cbe;
    logic [1:0]  pmode;   // 0: par_i=0, 1: right parity of previous vector, 2: wrong
    logic        eoe;
    logic        eperr;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    // R10 reset, then idle
    '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,32'h0,4'hF,2'd0,1'b0,1'b0},
    '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,32'h0,4'hF,2'd0,1'b0,1'b0},
    // initiator write: R2/R3 address, R4 data with wait, R7 completion, R9 wrong par_i ignored
    '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,32'h1234_5670,4'h7,2'd0,1'b1,1'b0},
    '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,32'hDEAD_BEEF,4'h0,2'd2,1'b1,1'b0},
    '{1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,32'hDEAD_BEEF,4'h0,2'd2,1'b1,1'b0},
    '{1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,32'hDEAD_BEEF,4'h0,2'd2,1'b0,1'b0},
    // target read: R3 target address, R6 live inputs flipped, R5 target drives
    '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,32'h0000_0F00,4'h6,2'd0,1'b0,1'b0},
    '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,32'h0,4'hF,2'd1,1'b0,1'b0},
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,32'hA5A5_0001,4'h3,2'd0,1'b1,1'b0},
    '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,32'h0,4'hF,2'd0,1'b0,1'b0},
    // initiator read: R5 initiator silent on data, R8 wrong data parity
    '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,32'h8000_0004,4'h6,2'd0,1'b1,1'b0},
    '{1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,32'h0102_0304,4'h0,2'd0,1'b0,1'b0},
    '{1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,32'h0,4'hF,2'd2,1'b0,1'b1},
    '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,32'h0,4'hF,2'd0,1'b0,1'b0},
    // target write: R8 wrong address parity, right data parity
    '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,32'h7FFF_FFFE,4'h7,2'd0,1'b0,1'b0},
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,32'h0F0F_F0F0,4'hA,2'd2,1'b0,1'b1},
    '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b1,32'h0,4'hF,2'd1,1'b0,1'b0},
    // R11 strobes outside a transaction
    '{1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,32'hFFFF_FFFF,4'h0,2'd0,1'b0,1'b0},
    '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,32'h0,4'hF,2'd0,1'b0,1'b0}
  };

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] ad_i;
  logic [3:0]  cbe_n_i;
  logic        frame_n_i, irdy_n_i, trdy_n_i, initiator_i, write_i, par_i;
  logic        par_o, par_oe_o, perr_pulse_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_parity_unit dut_i (
    .clk(clk), .rst(rst), .ad_i(ad_i), .cbe_n_i(cbe_n_i),
    .frame_n_i(frame_n_i), .irdy_n_i(irdy_n_i), .trdy_n_i(trdy_n_i),
    .initiator_i(initiator_i), .write_i(write_i), .par_i(par_i),
    .par_o(par_o), .par_oe_o(par_oe_o), .perr_pulse_o(perr_pulse_o)
  );

  function automatic logic even_bit(input logic [31:0] a, input logic [3:0] c);
    return ^{a, c};
  endfunction

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic r, input logic f, input logic ir, input logic tr,
                       input logic ini, input logic wr, input logic [31:0] a,
                       input logic [3:0] c, input logic p);
    rst = r; frame_n_i = f; irdy_n_i = ir; trdy_n_i = tr;
    initiator_i = ini; write_i = wr; ad_i = a; cbe_n_i = c; par_i = p;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    logic        pin;
    drive(1, 1, 1, 1, 0, 0, 0, 4'hF, 0);
    @(negedge clk);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      pin = 1'b0;
      if (i > 0 && VEC[i].pmode == 2'd1) pin = even_bit(VEC[i-1].ad, VEC[i-1].cbe);
      if (i > 0 && VEC[i].pmode == 2'd2) pin = ~even_bit(VEC[i-1].ad, VEC[i-1].cbe);
      drive(VEC[i].rst, VEC[i].frame_n, VEC[i].irdy_n, VEC[i].trdy_n,
            VEC[i].ini, VEC[i].wr, VEC[i].ad, VEC[i].cbe, pin);
      step();
      check(par_oe_o == VEC[i].eoe, $sformatf("vec %0d R3/R4/R5/R6/R11 par_oe_o", i),
            par_oe_o, VEC[i].eoe);
      check(perr_pulse_o == VEC[i].eperr, $sformatf("vec %0d R8/R9 perr_pulse_o", i),
            perr_pulse_o, VEC[i].eperr);
      if (VEC[i].eoe)
        check(par_o == even_bit(VEC[i].ad, VEC[i].cbe),
              $sformatf("vec %0d R1/R7 par_o", i), par_o, even_bit(VEC[i].ad, VEC[i].cbe));
    end

    // R1: initiator write burst with varying data and byte enables
    drive(0, 0, 1, 1, 1, 1, 32'hC000_0010, 4'h7, 0);
    step();
    check(par_oe_o && (par_o == even_bit(32'hC000_0010, 4'h7)), "R2 burst address parity",
          {par_oe_o, par_o}, {1'b1, even_bit(32'hC000_0010, 4'h7)});
    lfsr = 32'h1ACE_B00C;
    for (int k = 0; k < 12; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      drive(0, (k == 11), 0, 0, 1, 1, lfsr, lfsr[7:4], 0);
      step();
      check(par_oe_o && ($countones({par_o, lfsr, lfsr[7:4]}) % 2 == 0),
            $sformatf("R1 burst beat %0d even count", k), par_o, even_bit(lfsr, lfsr[7:4]));
    end
    drive(0, 1, 1, 1, 1, 1, 0, 4'hF, 0);
    step();
    check(!par_oe_o, "R7 enable released after final phase", par_oe_o, 0);

    // R10: reset in the middle of a transaction
    drive(0, 1, 1, 1, 0, 0, 0, 4'hF, 0);
    step();
    drive(0, 0, 1, 1, 0, 0, 32'h2222_0000, 4'h6, 0);
    step();
    drive(1, 1, 0, 1, 0, 0, 0, 4'hF, 1);
    step();
    check(!par_oe_o && !perr_pulse_o, "R10 outputs after mid-transaction reset",
          {par_oe_o, perr_pulse_o}, 0);
    drive(0, 1, 0, 0, 0, 0, 32'h3333_3333, 4'h0, 0);
    step();
    check(!par_oe_o, "R10/R11 no data phase survives reset", par_oe_o, 0);
    drive(0, 1, 1, 1, 0, 0, 0, 4'hF, 1);
    step();
    check(!perr_pulse_o, "R10 no compare after reset", perr_pulse_o, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule